// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns one source clock into two clock-enable streams. The first is a sampling tick for an infrared serial front end, intended to run near 1.8432 MHz. The second is a UART bit-rate tick at sixteen times oversampling. Each stream has an integer divisor and a 4-bit correction that adds sixteenths of a source cycle to the division period. The correction is realised by stretching chosen periods by one source cycle, so the average rate matches the fractional divisor. Software may accept up to 1 % error between the achieved rate and the target rate.

Software sets the divisors through a simple write port. A write of zero to the infrared divisor is illegal. It is rejected and sets a sticky flag. Any accepted divisor or correction write restarts both dividers from phase zero, so the tick pattern after the last write is fully determined. A small control register also lives here. It holds a transmit pulse-width select level and a self-clearing strobe that clears a receive pulse-width error.

Top module: `frac_baud_gen`

## Requirements
- R1: With infrared count C (address 2, bits [3:0]) and correction F (address 1, bits [7:4]), the k-th `irTick` after the edge that takes the last accepted configuration write arrives k·(C+1) + floor(k·F/16) cycles after that edge.
- R2: With UART count U (address 4, bits [11:0]) and correction G (address 3, bits [7:4]), the k-th `uartTick` after that edge arrives k·16·(U+1) + floor(k·G/16) cycles after it.
- R3: Only bits [7:4] of a correction write and only the count field of a count write take effect. All other data bits are ignored.
- R4: Writing 0 to the infrared count sets `cfgErr`. The flag stays set until reset, and the previous count stays in effect.
- R5: Every accepted write to addresses 1 to 4 restarts both dividers from phase zero, including the divider whose setting did not change. No tick appears in the cycle right after the restart.
- R6: Each tick is a one-cycle pulse and never stays high for two cycles in a row.
- R7: Address 0 is control. Bit 1 sets the `txPulseWide` level. Writing 1 to bit 0 makes `rxErrClr` high for exactly the one cycle after the write edge.
- R8: After reset, `cfgErr`, `txPulseWide` and `rxErrClr` are 0. The infrared count starts at its reset parameter (default 1), and all other fields start at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 16 | Register write data |
| irTick | output | 1 | Infrared sampling enable pulse |
| uartTick | output | 1 | UART 16x oversampling enable pulse |
| txPulseWide | output | 1 | Transmit pulse-width select level |
| rxErrClr | output | 1 | One-cycle clear for the receive pulse-width error |
| cfgErr | output | 1 | Sticky illegal-setting flag |

## Verification
A write is taken at one edge, and the register and restart strobe are updated at that edge. The divider loads its period at the next edge, so the k-th tick of each stream becomes visible exactly at the edge given by R1 and R2, counted from the write edge. The bench counts edges from the last write and samples every tick at the falling edge. It records the edge index of each of the first few ticks and compares it with the closed-form floor expression, which it computes independently of any accumulator. `rxErrClr` and `cfgErr` are due one edge after the write, so they are sampled at the falling edge that follows the write edge. The clear pulse is also checked to be gone one cycle later.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int FRAC_W = 4;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] ADDR_CTRL      = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_IR_FRAC   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_IR_CNT    = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_UART_FRAC = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_UART_CNT  = 3'd4;

  // correction field position inside its write word
  localparam int FRAC_LSB = 4;

  typedef struct packed {
    logic restart;   // reload both dividers at phase zero
    logic errClr;    // one-cycle receive error clear
  } strobe_t;
endpackage

// File: rtl/fbg_ctrl.sv
module fbg_ctrl
  import fbg_pkg::*;
#(
  parameter int IR_CNT_W   = 4,
  parameter int UART_CNT_W = 12,
  parameter int IR_CNT_RST = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [IR_CNT_W-1:0]   irCount,
  output logic [FRAC_W-1:0]     irFrac,
  output logic [UART_CNT_W-1:0] uartCount,
  output logic [FRAC_W-1:0]     uartFrac,
  output logic                  pulseWide,
  output logic                  cfgErr,
  output strobe_t               strb
);
  logic [FRAC_W-1:0]   fracField;
  logic [IR_CNT_W-1:0] irField;
  logic                irZero;
  logic                cfgAccept;

  assign fracField = wrData[FRAC_LSB +: FRAC_W];
  assign irField   = wrData[IR_CNT_W-1:0];
  assign irZero    = (irField == '0);

  always_comb begin
    cfgAccept = 1'b0;
    if (wrEn) begin
      unique case (wrAddr)
        ADDR_IR_FRAC, ADDR_UART_FRAC, ADDR_UART_CNT: cfgAccept = 1'b1;
        ADDR_IR_CNT:                                 cfgAccept = !irZero;
        default:                                     cfgAccept = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irCount     <= IR_CNT_W'(IR_CNT_RST);
      irFrac      <= '0;
      uartCount   <= '0;
      uartFrac    <= '0;
      pulseWide   <= 1'b0;
      cfgErr      <= 1'b0;
      strb.restart <= 1'b1;
      strb.errClr  <= 1'b0;
    end else begin
      strb.restart <= cfgAccept;
      strb.errClr  <= wrEn && (wrAddr == ADDR_CTRL) && wrData[0];
      if (wrEn) begin
        unique case (wrAddr)
          ADDR_CTRL:      pulseWide <= wrData[1];
          ADDR_IR_FRAC:   irFrac    <= fracField;
          ADDR_IR_CNT: begin
            if (irZero) cfgErr  <= 1'b1;
            else        irCount <= irField;
          end
          ADDR_UART_FRAC: uartFrac  <= fracField;
          ADDR_UART_CNT:  uartCount <= wrData[UART_CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);
  p_count_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN)
    irCount != '0);
  p_clr_from_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.errClr |-> $past(wrEn) && ($past(wrAddr) == ADDR_CTRL));
endmodule

// File: rtl/fbg_datapath.sv
module fbg_datapath
  import fbg_pkg::*;
#(
  parameter int IR_CNT_W   = 4,
  parameter int UART_CNT_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [IR_CNT_W-1:0]   irCount,
  input  logic [FRAC_W-1:0]     irFrac,
  input  logic [UART_CNT_W-1:0] uartCount,
  input  logic [FRAC_W-1:0]     uartFrac,
  output logic                  irTick,
  output logic                  uartTick
);
  localparam int CNT_MAX_W = (IR_CNT_W > UART_CNT_W) ? IR_CNT_W : UART_CNT_W;
  localparam int PER_W     = CNT_MAX_W + FRAC_W + 1;
  localparam int N_LANE    = 2;

  logic [PER_W-1:0]  base [N_LANE];
  logic [FRAC_W-1:0] frac [N_LANE];
  logic [N_LANE-1:0] tickVec;

  assign base[0] = PER_W'(irCount) + PER_W'(1);
  assign base[1] = (PER_W'(uartCount) + PER_W'(1)) << FRAC_W;
  assign frac[0] = irFrac;
  assign frac[1] = uartFrac;

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    logic [PER_W-1:0]  cnt;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;

    assign sum = {1'b0, acc} + {1'b0, frac[g]};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt <= '0;
        acc <= '0;
      end else if (strb.restart) begin
        cnt <= base[g] - PER_W'(1);
        acc <= frac[g];
      end else if (cnt == '0) begin
        cnt <= base[g] - PER_W'(1) + PER_W'(sum[FRAC_W]);
        acc <= sum[FRAC_W-1:0];
      end else begin
        cnt <= cnt - PER_W'(1);
      end
    end

    assign tickVec[g] = (cnt == '0) && !strb.restart;

    p_tick_single_r6: assert property (@(posedge clk) disable iff (!rstN)
      tickVec[g] |=> !tickVec[g]);
    p_no_early_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
      strb.restart |=> !tickVec[g]);
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rstN)
      !strb.restart |-> cnt <= base[g]);
  end

  assign irTick   = tickVec[0];
  assign uartTick = tickVec[1];
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int IR_CNT_W   = 4,
  parameter int UART_CNT_W = 12,
  parameter int IR_CNT_RST = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [15:0] wrData,
  output logic        irTick,
  output logic        uartTick,
  output logic        txPulseWide,
  output logic        rxErrClr,
  output logic        cfgErr
);
  strobe_t               strb;
  logic [IR_CNT_W-1:0]   irCount;
  logic [FRAC_W-1:0]     irFrac;
  logic [UART_CNT_W-1:0] uartCount;
  logic [FRAC_W-1:0]     uartFrac;

  fbg_ctrl #(
    .IR_CNT_W(IR_CNT_W), .UART_CNT_W(UART_CNT_W), .IR_CNT_RST(IR_CNT_RST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .irCount(irCount), .irFrac(irFrac), .uartCount(uartCount),
    .uartFrac(uartFrac), .pulseWide(txPulseWide), .cfgErr(cfgErr),
    .strb(strb)
  );

  fbg_datapath #(
    .IR_CNT_W(IR_CNT_W), .UART_CNT_W(UART_CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .irCount(irCount), .irFrac(irFrac),
    .uartCount(uartCount), .uartFrac(uartFrac),
    .irTick(irTick), .uartTick(uartTick)
  );

  assign rxErrClr = strb.errClr;
endmodule

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        irTick, uartTick, txPulseWide, rxErrClr, cfgErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  frac_baud_gen u_frac_baud_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .irTick(irTick), .uartTick(uartTick), .txPulseWide(txPulseWide),
    .rxErrClr(rxErrClr), .cfgErr(cfgErr)
  );

  // {irCount, irFrac, uartCount, uartFrac}
  localparam logic [15:0] VEC [7] = '{
    16'h1000, 16'h3408, 16'hFF1F, 16'h2101,
    16'h7823, 16'h1F0F, 16'h5AF5
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // edges counted from the last write edge; R1, R2 closed forms
  task automatic measure(input int irBase, input int irF,
                         input int uBase, input int uF);
    int irT[6];
    int uT[3];
    int ni = 0;
    int nu = 0;
    int win = 6 * (irBase + 1);
    if (3 * (uBase + 1) > win) win = 3 * (uBase + 1);
    win += 2;
    for (int n = 1; n <= win; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (irTick) begin if (ni < 6) irT[ni] = n; ni++; end
      if (uartTick) begin if (nu < 3) uT[nu] = n; nu++; end
    end
    for (int k = 1; k <= 6; k++)
      check("R1 ir tick time", (ni >= k) ? irT[k-1] : -1,
            k * irBase + (k * irF) / 16);
    for (int k = 1; k <= 3; k++)
      check("R2 uart tick time", (nu >= k) ? uT[k-1] : -1,
            k * uBase + (k * uF) / 16);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int lastIrC;
    int lastUC;
    int lastUF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8 cfgErr", cfgErr, 0);
    check("R8 txPulseWide", txPulseWide, 0);
    check("R8 rxErrClr", rxErrClr, 0);

    // R7 control register
    wr(3'd0, 16'h0003);
    check("R7 rxErrClr pulse", rxErrClr, 1);
    check("R7 txPulseWide", txPulseWide, 1);
    @(negedge clk);
    check("R7 rxErrClr single", rxErrClr, 0);
    wr(3'd0, 16'h0000);
    check("R7 txPulseWide off", txPulseWide, 0);

    // R1 R2 R3 R5 R6 vector walk; junk in unused data bits (R3)
    lastIrC = 1; lastUC = 0; lastUF = 0;
    foreach (VEC[i]) begin
      logic [3:0] irC = VEC[i][15:12];
      logic [3:0] irF = VEC[i][11:8];
      logic [3:0] uC  = VEC[i][7:4];
      logic [3:0] uF  = VEC[i][3:0];
      wr(3'd2, {12'hA50, irC});
      wr(3'd1, {8'hC3, irF, 4'h9});
      wr(3'd4, {4'hF, 8'h00, uC});
      wr(3'd3, {8'h3C, uF, 4'h6});
      measure(int'(irC) + 1, int'(irF), 16 * (int'(uC) + 1), int'(uF));
      lastIrC = int'(irC); lastUC = int'(uC); lastUF = int'(uF);
    end

    // R4 illegal infrared count
    wr(3'd2, 16'h0000);
    check("R4 cfgErr set", cfgErr, 1);
    // R5 restart by infrared-only write restarts UART too; R4 old count kept
    wr(3'd1, 16'h0027);
    measure(lastIrC + 1, 2, 16 * (lastUC + 1), lastUF);
    check("R4 cfgErr sticky", cfgErr, 1);

    finish_run();
  end
endmodule